// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a command written into a small register file into the pin-level cycles of an asynchronous 8-bit NAND device. One command word selects which phases run: a first command byte with CLE high, a programmable number of address bytes with ALE high, a short data transfer under host control, and a second command byte after which the block waits for the device's ready/busy line. Page read set-up, page program set-up, block erase, status read, identify read and reset are all built from these phases.

Software fills in the command bytes, address and timing, then writes the command word with its start bit set. The start bit reads back as one while the sequence runs. At the end a completion bit is raised in an interrupt-status register, and that bit is cleared by writing one to it. Up to four bytes read in host-driven mode are packed into one 32-bit response word. The write and read strobe widths come from a timing register, and a busy-wait limit ends a sequence that the device never releases.

Top module: `nand_seq`

## Requirements
- R1: After reset the command word reads 0, interrupt status reads 0, the status register reads 1 (ready, not busy), CE# is high and the timing register reads 0xFFFF0011.
- R2: Writing the command word (offset 0) with bit 0 set while idle starts a sequence. Bit 0 reads back as 1 until the sequence ends, and then interrupt-status bit 0 (done) is set.
- R3: Command word fields: bit1 first-command phase, bit2 address phase, bit3 second command plus ready wait, bit4 receive, bit5 transmit, bit6 host-driven data, bits[9:8] byte count minus one, bits[12:10] number of address bytes (1 to 5). Received bytes are stored in the response word (offset 7) with byte k in bits [8k+7:8k], and the word is cleared when a receive sequence starts.
- R4: The first command byte is taken from bits[7:0] of the opcode register (offset 1) and the second from bits[15:8]. A command with only the first-command phase (reset, 0xFF) produces exactly one CLE write cycle. A status command (0x70) with one receive byte produces one CLE cycle followed by one read cycle.
- R5: Address bytes are issued from the byte string {addr_hi[7:0], addr_lo[31:16], column} least significant first, where addr_lo is offset 2, addr_hi is offset 3 and column is addr_lo[15:0]. CLE and ALE are never high together.
- R6: When the second-command phase is enabled, done is not raised while R/B# is low; the go bit stays 1 and status bit 0 (R/B#) reads 0 in that time.
- R7: While a sequence runs, host writes to any register other than interrupt status are ignored.
- R8: With timing bit 8 set (16-bit bus) the column is shifted right by one before it is issued, only when the address count is 5; a 3-byte address is sent unchanged.
- R9: A transmit sequence sends its data bytes from offset 7 (byte 0 first) before the second command byte. A receive sequence with a second command reads its data only after the second command and the ready wait.
- R10: No data cycle occurs unless bit 6 of the command word is set.
- R11: WE# and RE# stay low for timing[3:0] clocks and high between bytes for timing[7:4]+1 clocks, a zero field counting as one; CLE and ALE are already valid one clock before WE# falls.
- R12: If R/B# stays low in the wait for timing[31:16] clocks, the sequence ends with interrupt-status bit 1 set, bit 0 clear and the go bit cleared.
- R13: Writing 1 to an interrupt-status bit clears it, writing 0 leaves it; a set by the sequencer in the same cycle wins.
- R14: With CE# high no strobe, CLE, ALE or bus drive is active; WE# and RE# are never low together; the block never drives the I/O bus while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register word offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus value driven to the device |
| nand_io_oe | output | 1 | I/O bus drive enable |
| nand_io_in | input | 8 | I/O bus value from the device |
| nand_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
A wrong phase state or byte index shows up within one byte cycle as a command, address or data byte that the device model logs in the wrong place or with the wrong value, so each sweep compares the full ordered log of latched bytes. A strobe-width counter off by one changes the measured WE# low time or gap on the very first byte. A wait state that misreads R/B# shows up as the go bit clearing while the model is still busy, or as a timeout flag where done was expected.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int          TWB_CYC = 3,
  parameter logic [31:0] CFG_RST = 32'hFFFF_0011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb_n
);
  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_DATA, S_CMD2, S_WAIT} st_t;

  st_t         state, nx;
  logic [12:1] ctl;
  logic [15:0] op, a2, wcnt;
  logic [31:0] a1, cfg, resp, txw;
  logic [1:0]  isr, sub;
  logic [3:0]  tcnt;
  logic [2:0]  idx;

  wire busy     = state != S_IDLE;
  wire start    = host_wr && host_addr == 3'd0 && host_wdata[0] && !busy;
  wire rx       = ctl[4];
  wire [3:0] lo_w = (cfg[3:0] == 4'd0) ? 4'd1 : cfg[3:0];
  wire [3:0] hi_w = (cfg[7:4] == 4'd0) ? 4'd1 : cfg[7:4];
  wire [15:0] col = (cfg[8] && ctl[12:10] == 3'd5) ? {1'b0, a1[15:1]} : a1[15:0];
  wire [63:0] abytes = {24'd0, a2[7:0], a1[31:16], col};
  wire bus_st   = state inside {S_CMD1, S_ADDR, S_DATA, S_CMD2};
  wire rd_ph    = state == S_DATA && rx;
  wire strobe   = bus_st && sub == 2'd1;
  wire lo_end   = strobe && tcnt == lo_w - 4'd1;
  wire byte_end = bus_st && sub == 2'd2 && tcnt == hi_w - 4'd1;
  wire rb_ok    = wcnt >= 16'(TWB_CYC) && nand_rb_n;
  wire tmo      = state == S_WAIT && !rb_ok && wcnt == cfg[31:16];

  function automatic st_t after_addr(input logic [12:1] c);
    if (c[4] && c[3]) return S_CMD2;
    if (c[6] && (c[4] || c[5])) return S_DATA;
    if (c[3]) return S_CMD2;
    return S_IDLE;
  endfunction

  always_comb begin
    nx = state;
    if (start)
      nx = host_wdata[1] ? S_CMD1 : host_wdata[2] ? S_ADDR : after_addr(host_wdata[12:1]);
    else if (byte_end)
      case (state)
        S_CMD1: nx = ctl[2] ? S_ADDR : after_addr(ctl);
        S_ADDR: if (idx == ctl[12:10] - 3'd1) nx = after_addr(ctl);
        S_DATA: if (idx[1:0] == ctl[9:8]) nx = (ctl[5] && !rx && ctl[3]) ? S_CMD2 : S_IDLE;
        S_CMD2: nx = S_WAIT;
        default: ;
      endcase
    else if (state == S_WAIT) begin
      if (rb_ok) nx = (rx && ctl[6]) ? S_DATA : S_IDLE;
      else if (tmo) nx = S_IDLE;
    end
  end

  wire fin = (busy || start) && nx == S_IDLE && !tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ctl <= '0; op <= '0; a1 <= '0; a2 <= '0; cfg <= CFG_RST;
      resp <= '0; txw <= '0; isr <= '0; sub <= '0; tcnt <= '0; idx <= '0; wcnt <= '0;
    end else begin
      state <= nx;
      if (nx != state) begin
        idx <= '0; sub <= '0; tcnt <= '0; wcnt <= '0;
      end else if (bus_st) begin
        case (sub)
          2'd0: begin sub <= 2'd1; tcnt <= '0; end
          2'd1: if (lo_end) begin sub <= 2'd2; tcnt <= '0; end else tcnt <= tcnt + 4'd1;
          default: if (byte_end) begin sub <= 2'd0; tcnt <= '0; idx <= idx + 3'd1; end
                   else tcnt <= tcnt + 4'd1;
        endcase
      end else if (state == S_WAIT) wcnt <= wcnt + 16'd1;
      if (lo_end && rd_ph) resp[{idx[1:0], 3'b000} +: 8] <= nand_io_in;
      if (start) begin
        ctl <= host_wdata[12:1];
        if (host_wdata[4]) resp <= '0;
      end
      if (host_wr && !busy)
        case (host_addr)
          3'd1: op  <= host_wdata[15:0];
          3'd2: a1  <= host_wdata;
          3'd3: a2  <= host_wdata[15:0];
          3'd4: cfg <= host_wdata;
          3'd7: txw <= host_wdata;
          default: ;
        endcase
      if (host_wr && host_addr == 3'd6) isr <= isr & ~host_wdata[1:0];
      if (fin) isr[0] <= 1'b1;
      if (tmo) isr[1] <= 1'b1;
    end
  end

  assign nand_ce_n  = !busy;
  assign nand_cle   = state == S_CMD1 || state == S_CMD2;
  assign nand_ale   = state == S_ADDR;
  assign nand_we_n  = !(strobe && !rd_ph);
  assign nand_re_n  = !(strobe && rd_ph);
  assign nand_io_oe = bus_st && !rd_ph;

  always_comb
    case (state)
      S_CMD1:  nand_io_out = op[7:0];
      S_CMD2:  nand_io_out = op[15:8];
      S_ADDR:  nand_io_out = abytes[{idx, 3'b000} +: 8];
      default: nand_io_out = txw[{idx[1:0], 3'b000} +: 8];
    endcase

  always_comb
    case (host_addr)
      3'd0:    host_rdata = {19'd0, ctl, busy};
      3'd1:    host_rdata = {16'd0, op};
      3'd2:    host_rdata = a1;
      3'd3:    host_rdata = {16'd0, a2};
      3'd4:    host_rdata = cfg;
      3'd5:    host_rdata = {30'd0, busy, nand_rb_n};
      3'd6:    host_rdata = {30'd0, isr};
      default: host_rdata = resp;
    endcase
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_io_oe
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R14
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe)); // R14
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe); // R14
  AST_LATCH_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale))); // R11
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R5
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_io_oe(nand_io_oe)
);

// File: tb/nand_seq_test.sv
module nand_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic ce_n, cle, ale, we_n, re_n, io_oe, rb_n;
  logic [7:0] io_out, io_in;

  always #2.5 clk = ~clk;

  nand_seq uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .nand_ce_n(ce_n),
    .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in), .nand_rb_n(rb_n)
  );

  localparam int C_CLE = 2, C_ALE = 4, C_SEC = 8, C_RX = 16, C_TX = 32, C_PIO = 64;
  localparam int BUSYN = 12;

  int checks = 0, fails = 0, bad = 0;
  int n = 0, en = 0, busy = 0, rk = 0;
  bit stuck = 1'b0, pwe = 1'b1, pre = 1'b1, cnt_hi = 1'b0;
  int lowc = 0, highc = 0, lw0 = -1, gap0 = -1;
  logic [7:0] rbase = 8'h00;
  logic [9:0] logv [32];
  logic [9:0] expv [32];

  assign rb_n  = !stuck && busy == 0;
  assign io_in = rbase + 8'(rk);

  always @(negedge clk) begin
    if (busy > 0) busy = busy - 1;
    if (!we_n && !re_n) bad++;
    if (ce_n && (!we_n || !re_n || cle || ale || io_oe)) bad++;
    if (!re_n && io_oe) bad++;
    if (!we_n) lowc++;
    if (we_n && cnt_hi) highc++;
    if (!pwe && we_n) begin
      if (n < 32) logv[n] = {(cle ? 2'd0 : ale ? 2'd1 : 2'd2), io_out};
      n++;
      if (cle && (io_out == 8'hD0 || io_out == 8'h30 || io_out == 8'h10)) busy = BUSYN;
      if (lw0 < 0) lw0 = lowc;
      lowc = 0; highc = 1; cnt_hi = 1'b1;
    end
    if (pwe && !we_n) begin
      if (cnt_hi && gap0 < 0) gap0 = highc;
      cnt_hi = 1'b0;
    end
    if (!pre && re_n) begin
      if (n < 32) logv[n] = {2'd3, io_in};
      n++; rk++;
    end
    pwe = we_n; pre = re_n;
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); host_addr = a; #1; v = host_rdata;
  endtask

  task automatic ex(input logic [1:0] t, input logic [7:0] v);
    expv[en] = {t, v}; en++;
  endtask

  task automatic launch(input int c);
    n = 0; en = 0; rk = 0; lw0 = -1; gap0 = -1; lowc = 0; cnt_hi = 1'b0;
    wr(3'd0, c | 1);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic cmp_log(input string r);
    chk({r, " byte count"}, n, en);
    for (int i = 0; i < en; i++)
      if (i < n) chk({r, " byte"}, {22'd0, logv[i]}, {22'd0, expv[i]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); chk("R1 command word", v, 0);
    rd(3'd6, v); chk("R1 interrupt status", v, 0);
    rd(3'd5, v); chk("R1 status", v, 1);
    rd(3'd4, v); chk("R1 timing", v, 32'hFFFF_0011);
    chk("R1 ce_n", {31'd0, ce_n}, 1);

    // R3 identify read, packed response, swept over device data
    for (int k = 0; k < 3; k++) begin
      rbase = 8'h10 + 8'(k * 8'h53);
      wr(3'd1, 32'h90); wr(3'd2, 0); wr(3'd6, 3);
      launch(C_CLE | C_ALE | C_RX | C_PIO | (3 << 8) | (1 << 10));
      wait_idle();
      ex(0, 8'h90); ex(1, 8'h00);
      for (int b = 0; b < 4; b++) ex(3, rbase + 8'(b));
      cmp_log("R3 identify");
      rd(3'd7, v);
      chk("R3 response packing", v, {rbase + 8'd3, rbase + 8'd2, rbase + 8'd1, rbase});
      rd(3'd6, v); chk("R2 done after identify", v, 1);
    end

    // R4 status: one CLE cycle, one read byte
    rbase = 8'hE0; wr(3'd1, 32'h70); wr(3'd6, 3);
    launch(C_CLE | C_RX | C_PIO);
    wait_idle();
    ex(0, 8'h70); ex(3, 8'hE0);
    cmp_log("R4 status");
    rd(3'd7, v); chk("R4 status response", v, 32'h0000_00E0);

    // R4 reset: CLE only
    wr(3'd1, 32'hFF);
    launch(C_CLE);
    wait_idle();
    ex(0, 8'hFF);
    cmp_log("R4 reset");

    // R5 R8 erase sweep, 3 address bytes never halved
    for (int k = 0; k < 3; k++) begin
      logic [31:0] pg;
      pg = 32'h0A5F3C + 32'(k) * 32'h51_2345;
      wr(3'd4, (k % 2 == 1) ? 32'hFFFF_0111 : 32'hFFFF_0011);
      wr(3'd1, 32'hD060); wr(3'd2, pg); wr(3'd6, 3);
      launch(C_CLE | C_ALE | C_SEC | (3 << 10));
      if (k == 0) begin
        for (int i = 0; i < 200 && n < 5; i++) @(negedge clk);
        rd(3'd0, v); chk("R6 go held while busy", {31'd0, v[0]}, 1);
        rd(3'd5, v); chk("R6 ready bit low while busy", {31'd0, v[0]}, 0);
        rd(3'd6, v); chk("R6 no done while busy", v, 0);
        wr(3'd1, 32'h1234);
        wr(3'd0, C_CLE | 1);
      end
      wait_idle();
      ex(0, 8'h60); ex(1, pg[7:0]); ex(1, pg[15:8]); ex(1, pg[23:16]); ex(0, 8'hD0);
      cmp_log("R5 erase");
      rd(3'd6, v); chk("R2 done after erase", v, 1);
      if (k == 0) begin
        rd(3'd1, v); chk("R7 opcode write ignored while busy", v, 32'hD060);
      end
    end

    // R5 R8 page read set-up sweep over bus width and column
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 3; k++) begin
        logic [15:0] c, ce;
        logic [23:0] pg;
        c  = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0841 : 16'h07FF;
        ce = (w == 1) ? (c >> 1) : c;
        pg = 24'h12_3456 + 24'(k) * 24'h01_1111;
        wr(3'd4, (w == 1) ? 32'hFFFF_0111 : 32'hFFFF_0011);
        wr(3'd1, 32'h3000); wr(3'd2, {pg[15:0], c}); wr(3'd3, {24'd0, pg[23:16]});
        launch(C_CLE | C_ALE | C_SEC | (5 << 10));
        wait_idle();
        ex(0, 8'h00); ex(1, ce[7:0]); ex(1, ce[15:8]);
        ex(1, pg[7:0]); ex(1, pg[15:8]); ex(1, pg[23:16]); ex(0, 8'h30);
        cmp_log(w == 1 ? "R8 page read halved column" : "R5 page read address order");
      end
    wr(3'd4, 32'hFFFF_0011);

    // R9 program: data before second command
    wr(3'd1, 32'h1080); wr(3'd2, 32'h0002_0010); wr(3'd3, 0); wr(3'd7, 32'hA1B2C3D4);
    launch(C_CLE | C_ALE | C_SEC | C_TX | C_PIO | (3 << 8) | (5 << 10));
    wait_idle();
    ex(0, 8'h80); ex(1, 8'h10); ex(1, 8'h00); ex(1, 8'h02); ex(1, 8'h00); ex(1, 8'h00);
    ex(2, 8'hD4); ex(2, 8'hC3); ex(2, 8'hB2); ex(2, 8'hA1); ex(0, 8'h10);
    cmp_log("R9 program order");

    // R9 read with data after second command and ready
    rbase = 8'h40; wr(3'd1, 32'h3000);
    launch(C_CLE | C_ALE | C_SEC | C_RX | C_PIO | (1 << 8) | (5 << 10));
    wait_idle();
    ex(0, 8'h00); ex(1, 8'h10); ex(1, 8'h00); ex(1, 8'h02); ex(1, 8'h00); ex(1, 8'h00);
    ex(0, 8'h30); ex(3, 8'h40); ex(3, 8'h41);
    cmp_log("R9 read data after ready");
    rd(3'd7, v); chk("R9 read response", v, 32'h0000_4140);

    // R10 receive without host-driven data enable
    wr(3'd1, 32'h70);
    launch(C_CLE | C_RX | (3 << 8));
    wait_idle();
    ex(0, 8'h70);
    cmp_log("R10 no data without enable");

    // R11 strobe width sweep
    wr(3'd1, 32'hD060); wr(3'd2, 32'h0000_0123);
    for (int lo = 0; lo < 4; lo++)
      for (int hi = 0; hi < 4; hi++) begin
        wr(3'd4, 32'hFFFF_0000 | (hi << 4) | lo);
        launch(C_CLE | C_ALE | C_SEC | (3 << 10));
        wait_idle();
        chk("R11 WE# low width", lw0, (lo == 0) ? 1 : lo);
        chk("R11 WE# high gap", gap0, ((hi == 0) ? 1 : hi) + 1);
      end

    // R12 timeout on stuck busy
    wr(3'd4, 32'h0014_0011); wr(3'd6, 3);
    stuck = 1'b1;
    launch(C_CLE | C_ALE | C_SEC | (3 << 10));
    wait_idle();
    rd(3'd6, v); chk("R12 timeout flag without done", v, 2);
    rd(3'd0, v); chk("R12 go cleared after timeout", {31'd0, v[0]}, 0);
    stuck = 1'b0;
    wr(3'd4, 32'hFFFF_0011);

    // R13 write-one-to-clear
    wr(3'd1, 32'hFF);
    launch(C_CLE);
    wait_idle();
    rd(3'd6, v); chk("R13 both bits set", v, 3);
    wr(3'd6, 1); rd(3'd6, v); chk("R13 clear done only", v, 2);
    wr(3'd6, 0); rd(3'd6, v); chk("R13 zero write keeps", v, 2);
    wr(3'd6, 2); rd(3'd6, v); chk("R13 clear error", v, 0);

    chk("R14 pin rule violations", bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule